// File: doc/BRIEF.md
# Loop Handshake Controller

This block sequences a hardware `while` loop using valid/ready handshakes. A parent starts it by raising `start_i`. The controller then requests a condition evaluation from a compare unit and waits until that unit reports completion with a result it marks as readable. A true result launches one pass of the loop body through a second handshake. A false result ends the loop.

Each body pass is fully retired before the next evaluation begins. The controller drops the body request once the body reports done, and waits for that done to fall. It then raises a fresh compare request. When the loop ends, the controller holds `done_o` until the parent withdraws `start_i`, and then returns to idle. The compare and body datapaths sit outside the block. Only their control handshakes pass through it.

Top module: `loop_handshake_ctrl`

## Requirements
- R1: While `rst_n` is low, `done_o`, `cond_en_o` and `body_en_o` are all 0, and the controller returns to idle.
- R2: In idle, the controller stays idle with all outputs 0 while `start_i` is 0, whatever the other inputs do. The cycle after `start_i` is 1, `cond_en_o` is 1.
- R3: While `cond_en_o` is 1, the controller keeps waiting with `cond_en_o` held at 1 unless `cond_done_i` and `cond_valid_i` are both 1 in the same cycle. The value of `cond_i` has no effect while it waits.
- R4: When `cond_en_o`, `cond_done_i`, `cond_valid_i` and `cond_i` are all 1, the next cycle has `body_en_o` = 1 and `cond_en_o` = 0.
- R5: When `cond_en_o`, `cond_done_i` and `cond_valid_i` are 1 and `cond_i` is 0, the next cycle has `done_o` = 1 and `body_en_o` = 0. A loop whose first evaluation is false never raises `body_en_o`.
- R6: `body_en_o` stays 1 until `body_done_i` is 1, and then falls. After that, all outputs stay 0 while `body_done_i` remains 1. The cycle after `body_done_i` is seen at 0, `cond_en_o` is 1.
- R7: `done_o` stays 1 while `start_i` is 1. The cycle after `start_i` is seen at 0 in that state, all outputs are 0 and the controller is idle.
- R8: At most one of `done_o`, `cond_en_o` and `body_en_o` is 1 in any cycle.
- R9: Between two condition evaluations, `cond_en_o` is 0 for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request from the parent to run the loop |
| cond_done_i | input | 1 | Compare unit has finished |
| cond_i | input | 1 | Compare result (1 = keep looping) |
| cond_valid_i | input | 1 | Compare result is readable |
| body_done_i | input | 1 | Body unit has finished one pass |
| done_o | output | 1 | Loop has finished; held until `start_i` falls |
| cond_en_o | output | 1 | Request to the compare unit |
| body_en_o | output | 1 | Request to the body unit |

## Verification
The bench targets four corner cases.

- A compare completion without its readable tag, carrying a false result. A design that trusted `cond_done_i` alone would exit the loop early.
- A body done that stays high for several cycles. A design that skipped the release wait would restart the compare while the body handshake was still closing, or would run a spurious extra pass.
- A loop that is false on its first evaluation. This must reach `done_o` without ever raising `body_en_o`.
- Back-to-back runs and a reset applied in the middle of a body pass. These show whether a design drops `done_o` and returns cleanly to idle.

// File: rtl/loop_ctrl_pkg.sv
package loop_ctrl_pkg;

    typedef enum logic [2:0] {
        LS_IDLE  = 3'd0,
        LS_EVAL  = 3'd1,
        LS_BODY  = 3'd2,
        LS_DRAIN = 3'd3,
        LS_DONE  = 3'd4
    } loop_state_e;

    typedef struct packed {
        loop_state_e state;
    } loop_regs_t;

    typedef struct packed {
        logic done;
        logic cond_en;
        logic body_en;
    } loop_outs_t;

endpackage

// File: rtl/loop_ctrl_next.sv
module loop_ctrl_next
    import loop_ctrl_pkg::*;
(
    input  loop_regs_t regs_q,
    input  logic       start_i,
    input  logic       cond_done_i,
    input  logic       cond_i,
    input  logic       cond_valid_i,
    input  logic       body_done_i,
    output loop_regs_t regs_d
);

    logic cond_seen;

    // The compare result counts only when completion and the readable tag coincide.
    assign cond_seen = cond_done_i & cond_valid_i;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            LS_IDLE: begin
                if (start_i) regs_d.state = LS_EVAL;
            end
            LS_EVAL: begin
                if (cond_seen) regs_d.state = cond_i ? LS_BODY : LS_DONE;
            end
            LS_BODY: begin
                if (body_done_i) regs_d.state = LS_DRAIN;
            end
            LS_DRAIN: begin
                if (!body_done_i) regs_d.state = LS_EVAL;
            end
            LS_DONE: begin
                if (!start_i) regs_d.state = LS_IDLE;
            end
            default: regs_d.state = LS_IDLE;
        endcase
    end

endmodule

// File: rtl/loop_ctrl_decode.sv
module loop_ctrl_decode
    import loop_ctrl_pkg::*;
(
    input  loop_regs_t regs_q,
    output loop_outs_t outs
);

    always_comb begin
        outs = '0;
        unique case (regs_q.state)
            LS_EVAL: outs.cond_en = 1'b1;
            LS_BODY: outs.body_en = 1'b1;
            LS_DONE: outs.done    = 1'b1;
            default: outs         = '0;
        endcase
    end

endmodule

// File: rtl/loop_handshake_ctrl.sv
module loop_handshake_ctrl
    import loop_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cond_done_i,
    input  logic cond_i,
    input  logic cond_valid_i,
    input  logic body_done_i,
    output logic done_o,
    output logic cond_en_o,
    output logic body_en_o
);

    loop_regs_t regs_q;
    loop_regs_t regs_d;
    loop_regs_t nxt;
    loop_outs_t outs;

    loop_ctrl_next i_next (
        .regs_q      (regs_q),
        .start_i     (start_i),
        .cond_done_i (cond_done_i),
        .cond_i      (cond_i),
        .cond_valid_i(cond_valid_i),
        .body_done_i (body_done_i),
        .regs_d      (nxt)
    );

    loop_ctrl_decode i_decode (
        .regs_q(regs_q),
        .outs  (outs)
    );

    always_comb begin
        regs_d = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '{state: LS_IDLE};
        else        regs_q <= regs_d;
    end

    assign done_o    = outs.done;
    assign cond_en_o = outs.cond_en;
    assign body_en_o = outs.body_en;

    // R8
    excl_outs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, cond_en_o, body_en_o}));

    // R3
    eval_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_en_o && !(cond_done_i && cond_valid_i)) |=> cond_en_o);

    // R4
    cond_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_en_o && cond_done_i && cond_valid_i && cond_i) |=> (body_en_o && !cond_en_o));

    // R5
    cond_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_en_o && cond_done_i && cond_valid_i && !cond_i) |=> (done_o && !body_en_o));

    // R6
    body_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (body_en_o && !body_done_i) |=> body_en_o);

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> done_o);

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    // R9
    eval_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        body_en_o |=> !cond_en_o);

endmodule

// File: tb/test_loop_handshake_ctrl.sv
module test_loop_handshake_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic cond_done_i = 1'b0;
    logic cond_i = 1'b0;
    logic cond_valid_i = 1'b0;
    logic body_done_i = 1'b0;
    logic done_o;
    logic cond_en_o;
    logic body_en_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    loop_handshake_ctrl i_loop_handshake_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cond_done_i (cond_done_i),
        .cond_i      (cond_i),
        .cond_valid_i(cond_valid_i),
        .body_done_i (body_done_i),
        .done_o      (done_o),
        .cond_en_o   (cond_en_o),
        .body_en_o   (body_en_o)
    );

    // Vector: req[11:8], start, cond_done, cond_valid, cond, body_done, exp done, exp cond_en, exp body_en
    localparam int NV = 19;
    localparam logic [11:0] VEC [NV] = '{
        {4'd2, 5'b00000, 3'b000},  // R2 idle holds
        {4'd2, 5'b01111, 3'b000},  // R2 idle ignores the handshake inputs
        {4'd2, 5'b10000, 3'b010},  // R2 start leads to evaluation
        {4'd3, 5'b10110, 3'b010},  // R3 readable tag without done
        {4'd3, 5'b11000, 3'b010},  // R3 done without readable tag, false ignored
        {4'd4, 5'b11110, 3'b001},  // R4 true result enters the body
        {4'd6, 5'b10000, 3'b001},  // R6 body held
        {4'd6, 5'b10001, 3'b000},  // R6 body done releases
        {4'd6, 5'b10001, 3'b000},  // R6 waits for done to fall
        {4'd9, 5'b10000, 3'b010},  // R9 fresh evaluation after the gap
        {4'd4, 5'b11110, 3'b001},  // R4 second pass
        {4'd6, 5'b10001, 3'b000},  // R6 release
        {4'd9, 5'b10000, 3'b010},  // R9 re-evaluate
        {4'd5, 5'b11100, 3'b100},  // R5 false result finishes
        {4'd7, 5'b11111, 3'b100},  // R7 done held while start is high
        {4'd7, 5'b00000, 3'b000},  // R7 start low returns to idle
        {4'd2, 5'b10000, 3'b010},  // R2 second run
        {4'd5, 5'b11100, 3'b100},  // R5 zero-iteration loop
        {4'd7, 5'b00000, 3'b000}   // R7 back to idle
    };

    task automatic check3(input int req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: done/cond_en/body_en actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] v);
        {start_i, cond_done_i, cond_valid_i, cond_i, body_done_i} = v;
    endtask

    initial begin
        bit body_seen;
        repeat (3) @(posedge clk);
        #2;
        check3(1, {done_o, cond_en_o, body_en_o}, 3'b000);  // R1 reset state
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][7:3]);
            @(posedge clk);
            #2;
            check3(int'(VEC[i][11:8]), {done_o, cond_en_o, body_en_o}, VEC[i][2:0]);
            // R8 exclusive outputs
            checks++;
            if ($countones({done_o, cond_en_o, body_en_o}) > 1) begin
                errors++;
                $display("FAIL R8: outputs %b expected at most one high",
                         {done_o, cond_en_o, body_en_o});
            end
        end

        // R5 zero-iteration run never raises body_en_o
        body_seen = 1'b0;
        @(negedge clk); drive(5'b10000);
        @(posedge clk); #2; body_seen |= body_en_o;
        @(negedge clk); drive(5'b11100);
        @(posedge clk); #2; body_seen |= body_en_o;
        check3(5, {done_o, cond_en_o, body_seen}, 3'b100);
        @(negedge clk); drive(5'b00000);
        @(posedge clk); #2;
        check3(7, {done_o, cond_en_o, body_en_o}, 3'b000);

        // R6 body done already high on the cycle the body starts
        @(negedge clk); drive(5'b10000);
        @(posedge clk); #2;
        @(negedge clk); drive(5'b11111);
        @(posedge clk); #2;
        check3(4, {done_o, cond_en_o, body_en_o}, 3'b001);
        @(negedge clk); drive(5'b10001);
        @(posedge clk); #2;
        check3(6, {done_o, cond_en_o, body_en_o}, 3'b000);

        // R1 reset in the middle of a loop
        @(negedge clk); drive(5'b10000);
        @(posedge clk); #2;
        @(negedge clk); drive(5'b11110);
        @(posedge clk); #2;
        check3(4, {done_o, cond_en_o, body_en_o}, 3'b001);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2;
        check3(1, {done_o, cond_en_o, body_en_o}, 3'b000);
        @(negedge clk); rst_n = 1'b1; drive(5'b00000);
        @(posedge clk); #2;
        check3(1, {done_o, cond_en_o, body_en_o}, 3'b000);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule